// File: doc/BRIEF.md
# Dual-Context Configurable Logic Tile

This block is a single tile of a fine-grained reconfigurable fabric. It receives one bit from each nearest neighbour (north, south, east, west) and one bit from each of four length-4 lines. Three 8-way operand selectors choose X1, X2 and X3 from that pool of eight bits. X2 and X3 are each shaped into Y2 and Y3, which can be the operand itself, its complement, a constant 0 or a constant 1. The logic result is then F = X1 ? Y2 : Y3, so AND, OR and every other two-input function come purely from how the operands are assigned. F leaves the tile either directly or through a flip-flop with a synchronous clear. Four 4-way routing selectors drive the neighbour outputs. Each of them carries either F or one of the three neighbour inputs that did not arrive from its own side.

The tile keeps two complete 24-bit configuration words. A one-bit context select swaps the whole logic and routing function from one word to the other. The select is held in a two-state register, with states CTX_ZERO and CTX_ONE. On every clock edge the register takes transition HOLD when the select matches the current state, SWITCH_UP when it moves from CTX_ZERO to CTX_ONE, and SWITCH_DOWN when it moves from CTX_ONE to CTX_ZERO. Both words are loaded through a parallel write port made of an index, a data word and a write enable. Any word can be written while the other one keeps the tile running.

Configuration word layout:

| Bits | Field |
|------|-------|
| [2:0] | X1 source |
| [5:3] | X2 source |
| [8:6] | X3 source |
| [10:9] | Y2 shaping |
| [12:11] | Y3 shaping |
| [13] | output from flip-flop when 1 |
| [15:14] | north output route |
| [17:16] | south output route |
| [19:18] | east output route |
| [21:20] | west output route |
| [23:22] | unused |

Top module: `lcell_tile`

## Requirements
- R1: After reset both configuration words are zero, context 0 is active and the flip-flop holds 0. With a zero word, F equals the north neighbour input and all four directional outputs equal F; this also holds after switching to context 1 with no write.
- R2: Operand source codes 0..7 select, in order, nb_in[0] (N), nb_in[1] (S), nb_in[2] (E), nb_in[3] (W), far_in[0] (N4), far_in[1] (S4), far_in[2] (E4) and far_in[3] (W4).
- R3: Shaping codes 0 = operand, 1 = complement, 2 = constant 0, 3 = constant 1. Combinational F equals Y2 when X1 is 1 and Y3 when X1 is 0, always in true polarity.
- R4: With X1 = a, X2 = b, Y2 = operand and Y3 = 0, F equals a AND b. With X1 = a, Y2 = 1, X3 = b and Y3 = operand, F equals a OR b.
- R5: With bit 13 set, cell_f shows the value of combinational F sampled at the previous rising edge and holds it between edges.
- R6: clr high at a rising edge loads 0 into the flip-flop, whatever F is.
- R7: Route code 0 sends F to that side. Codes 1..3 send the other three neighbour inputs in ascending N, S, E, W order, skipping the output's own side. An output never carries its own side's input.
- R8: A change of ctx_sel takes effect at the next rising edge. Up to that edge the previous word still drives every selector. The value the flip-flop captures at that edge is the F of the previous context.
- R9: A write to the word that is not active, while ctx_sel is steady, leaves every output unchanged. After a later switch, the written word is in force.
- R10: Toggling ctx_sel on every cycle, between a word holding AND and a word holding OR, alternates the function on successive cycles.
- R11: Bits [23:22] of a word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the output flip-flop |
| ctx_sel | input | 1 | Requested configuration context |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 1 | Context index of the write |
| cfg_data | input | 24 | Configuration word to write |
| nb_in | input | 4 | Nearest-neighbour inputs {W,E,S,N} |
| far_in | input | 4 | Length-4 inputs {W4,E4,S4,N4} |
| cell_f | output | 1 | Logic output F (direct or registered) |
| dir_out | output | 4 | Directional outputs {W,E,S,N} |

## Verification
Results arrive at different times:
- A change on nb_in or far_in under a steady context reaches cell_f and dir_out in the same cycle.
- A configuration write, a ctx_sel change, a clear and the registered output each show only after one rising edge.

The bench drives every input just after a falling edge. For combinational results it samples 1 ns later. For edge-timed results it first samples before the rising edge, to confirm the old value still holds, and then samples 1 ns after that edge for the new one. The context-switch checks on the registered path span two edges: the first edge captures F under the old word, and the second captures F under the new one.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int NSIDE   = 4;
    localparam int NPOOL   = 2 * NSIDE;
    localparam int SEL_W   = $clog2(NPOOL);
    localparam int RT_W    = 2;
    localparam int CFG_W   = 24;
    localparam int NCTX    = 2;
    localparam int IDX_W   = $clog2(NCTX);

    typedef enum logic [1:0] {
        YM_PASS = 2'd0,
        YM_INV  = 2'd1,
        YM_ZERO = 2'd2,
        YM_ONE  = 2'd3
    } ymode_t;

    typedef enum logic {
        CTX_ZERO = 1'b0,
        CTX_ONE  = 1'b1
    } ctx_state_t;

    typedef struct packed {
        logic [1:0]      spare;
        logic [RT_W-1:0] rt_w;
        logic [RT_W-1:0] rt_e;
        logic [RT_W-1:0] rt_s;
        logic [RT_W-1:0] rt_n;
        logic            reg_en;
        ymode_t          y3m;
        ymode_t          y2m;
        logic [SEL_W-1:0] x3s;
        logic [SEL_W-1:0] x2s;
        logic [SEL_W-1:0] x1s;
    } cfg_t;

    function automatic logic shape_bit(ymode_t m, logic x);
        case (m)
            YM_PASS: return x;
            YM_INV:  return ~x;
            YM_ZERO: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/lcell_ctx_store.sv
module lcell_ctx_store
    import lcell_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctx_sel,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [W-1:0]     cfg_data,
    output logic [W-1:0]     act_word,
    output logic             ctx_act
);

    logic [W-1:0] word_q [NCTX];
    ctx_state_t   cur_st;
    ctx_state_t   nxt_st;

    // both configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTX; i++) word_q[i] <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NCTX; i++) begin
                if (cfg_idx == IDX_W'(i)) word_q[i] <= cfg_data;
            end
        end
    end

    // context state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= CTX_ZERO;
        else        cur_st <= nxt_st;
    end

    // transitions: HOLD, SWITCH_UP, SWITCH_DOWN
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            CTX_ZERO: if (ctx_sel)  nxt_st = CTX_ONE;
            CTX_ONE:  if (!ctx_sel) nxt_st = CTX_ZERO;
        endcase
    end

    // outputs
    always_comb begin
        act_word = word_q[0];
        ctx_act  = 1'b0;
        unique case (cur_st)
            CTX_ZERO: begin
                act_word = word_q[0];
                ctx_act  = 1'b0;
            end
            CTX_ONE: begin
                act_word = word_q[1];
                ctx_act  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lcell_core.sv
module lcell_core
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] x1s,
    input  logic [SEL_W-1:0] x2s,
    input  logic [SEL_W-1:0] x3s,
    input  ymode_t           y2m,
    input  ymode_t           y3m,
    input  logic             reg_en,
    input  logic [NSIDE-1:0] nb_in,
    input  logic [NSIDE-1:0] far_in,
    output logic             f_comb,
    output logic             f_q,
    output logic             f_out
);

    logic [NPOOL-1:0] pool;
    logic x1, x2, x3, y2, y3;

    assign pool = {far_in, nb_in};

    always_comb begin
        x1     = pool[x1s];
        x2     = pool[x2s];
        x3     = pool[x3s];
        y2     = shape_bit(y2m, x2);
        y3     = shape_bit(y3m, x3);
        f_comb = x1 ? y2 : y3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   f_q <= 1'b0;
        else if (clr) f_q <= 1'b0;
        else          f_q <= f_comb;
    end

    assign f_out = reg_en ? f_q : f_comb;

endmodule

// File: rtl/lcell_route.sv
module lcell_route
    import lcell_pkg::*;
(
    input  logic                      f,
    input  logic [NSIDE-1:0]          nb_in,
    input  logic [NSIDE-1:0][RT_W-1:0] rt_sel,
    output logic [NSIDE-1:0]          dir_out
);

    for (genvar d = 0; d < NSIDE; d++) begin : g_side
        logic [RT_W-1:0] k;
        logic [RT_W-1:0] src;
        always_comb begin
            k   = rt_sel[d] - RT_W'(1);
            src = (k < RT_W'(d)) ? k : k + RT_W'(1);
            if (rt_sel[d] == '0) dir_out[d] = f;
            else                 dir_out[d] = nb_in[src];
        end
    end

endmodule

// File: rtl/lcell_tile.sv
module lcell_tile
    import lcell_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        ctx_sel,
    input  logic        cfg_we,
    input  logic        cfg_idx,
    input  logic [23:0] cfg_data,
    input  logic [3:0]  nb_in,
    input  logic [3:0]  far_in,
    output logic        cell_f,
    output logic [3:0]  dir_out
);

    logic [CFG_W-1:0]             act_word;
    logic                         ctx_act;
    cfg_t                         cw;
    logic                         f_comb;
    logic                         f_q;
    logic [NSIDE-1:0][RT_W-1:0]   rt_sel;
    logic [1:0]                   spare_unused;

    lcell_ctx_store #(.W(CFG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctx_sel  (ctx_sel),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .act_word (act_word),
        .ctx_act  (ctx_act)
    );

    assign cw           = cfg_t'(act_word);
    assign spare_unused = cw.spare;
    assign rt_sel       = {cw.rt_w, cw.rt_e, cw.rt_s, cw.rt_n};

    lcell_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .x1s    (cw.x1s),
        .x2s    (cw.x2s),
        .x3s    (cw.x3s),
        .y2m    (cw.y2m),
        .y3m    (cw.y3m),
        .reg_en (cw.reg_en),
        .nb_in  (nb_in),
        .far_in (far_in),
        .f_comb (f_comb),
        .f_q    (f_q),
        .f_out  (cell_f)
    );

    lcell_route u_route (
        .f       (cell_f),
        .nb_in   (nb_in),
        .rt_sel  (rt_sel),
        .dir_out (dir_out)
    );

endmodule

// File: rtl/lcell_tile_chk.sv
module lcell_tile_chk
    import lcell_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clr,
    input logic                       ctx_sel,
    input logic                       cfg_we,
    input logic                       cfg_idx,
    input logic                       ctx_act,
    input logic [CFG_W-1:0]           act_word,
    input logic                       f_comb,
    input logic                       f_q,
    input logic                       cell_f,
    input logic [NSIDE-1:0][RT_W-1:0] rt_sel,
    input logic [NSIDE-1:0]           dir_out
);

    // R8
    ctx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_sel |=> ctx_act);

    // R8
    ctx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_sel |=> !ctx_act);

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !f_q);

    // R5
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (f_q == $past(f_comb)));

    // R9
    idle_word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_idx != ctx_act) && (ctx_sel == ctx_act)) |=> $stable(act_word));

    for (genvar d = 0; d < NSIDE; d++) begin : g_rt
        // R7
        route_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rt_sel[d] == '0) |-> (dir_out[d] == cell_f));
    end

endmodule

bind lcell_tile lcell_tile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .ctx_sel  (ctx_sel),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .ctx_act  (ctx_act),
    .act_word (act_word),
    .f_comb   (f_comb),
    .f_q      (f_q),
    .cell_f   (cell_f),
    .rt_sel   (rt_sel),
    .dir_out  (dir_out)
);

// File: tb/tb_lcell_tile.sv
`timescale 1ns/1ps
module tb_lcell_tile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        ctx_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_idx = 1'b0;
    logic [23:0] cfg_data = '0;
    logic [3:0]  nb_in = '0;
    logic [3:0]  far_in = '0;
    logic        cell_f;
    logic [3:0]  dir_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic run_done = 1'b0;

    always #4 clk = ~clk;

    lcell_tile dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ctx_sel(ctx_sel),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .nb_in(nb_in), .far_in(far_in), .cell_f(cell_f), .dir_out(dir_out)
    );

    // ---------------- reference model ----------------
    function automatic logic [23:0] mk(input int x1, input int x2, input int x3,
                                       input int y2m, input int y3m, input int rg,
                                       input int rn, input int rs, input int re, input int rw);
        logic [23:0] c;
        c = '0;
        c[2:0]   = 3'(x1);
        c[5:3]   = 3'(x2);
        c[8:6]   = 3'(x3);
        c[10:9]  = 2'(y2m);
        c[12:11] = 2'(y3m);
        c[13]    = 1'(rg);
        c[15:14] = 2'(rn);
        c[17:16] = 2'(rs);
        c[19:18] = 2'(re);
        c[21:20] = 2'(rw);
        return c;
    endfunction

    function automatic logic pick(input logic [2:0] s, input logic [3:0] nb, input logic [3:0] far);
        if (s < 3'd4) return nb[s[1:0]];
        return far[s[1:0]];
    endfunction

    function automatic logic shp(input logic [1:0] m, input logic x);
        if (m == 2'd0) return x;
        if (m == 2'd1) return !x;
        if (m == 2'd2) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic mdl_f(input logic [23:0] c, input logic [3:0] nb, input logic [3:0] far);
        logic a, y2, y3;
        a  = pick(c[2:0], nb, far);
        y2 = shp(c[10:9], pick(c[5:3], nb, far));
        y3 = shp(c[12:11], pick(c[8:6], nb, far));
        return a ? y2 : y3;
    endfunction

    function automatic logic mdl_dir(input logic [23:0] c, input int d, input logic f, input logic [3:0] nb);
        int sel, cnt;
        sel = int'(c[14 + 2*d +: 2]);
        if (sel == 0) return f;
        cnt = 0;
        for (int j = 0; j < 4; j++) begin
            if (j != d) begin
                cnt++;
                if (cnt == sel) return nb[j];
            end
        end
        return 1'b0;
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_comb(input string req, input logic [23:0] c);
        logic ef;
        logic [3:0] ed;
        ef = mdl_f(c, nb_in, far_in);
        for (int d = 0; d < 4; d++) ed[d] = mdl_dir(c, d, ef, nb_in);
        chk(req, {dir_out, cell_f}, {ed, ef});
    endtask

    task automatic write_cfg(input logic idx, input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ctx(input logic v);
        @(negedge clk);
        ctx_sel = v;
        @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] nb, input logic [3:0] far);
        @(negedge clk);
        nb_in = nb; far_in = far;
        #1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'b0001, 4'b0000);
        chk("R1", {dir_out, cell_f}, 5'b11111);
        drive(4'b1110, 4'b1111);
        chk("R1", {dir_out, cell_f}, 5'b00000);
        set_ctx(1'b1);
        drive(4'b0001, 4'b0000);
        chk("R1", {dir_out, cell_f}, 5'b11111);
        set_ctx(1'b0);
    endtask

    task automatic t_operand();
        logic [7:0] pool;
        for (int s = 0; s < 8; s++) begin
            write_cfg(1'b0, mk(s, s, s, 0, 0, 0, 0, 0, 0, 0));
            pool = 8'(1 << s);
            drive(pool[3:0], pool[7:4]);
            chk("R2", {4'b0, cell_f}, 5'b00001);
            pool = ~pool;
            drive(pool[3:0], pool[7:4]);
            chk("R2", {4'b0, cell_f}, 5'b00000);
        end
    endtask

    task automatic t_ymodes();
        logic [23:0] c;
        for (int m2 = 0; m2 < 4; m2++) begin
            for (int m3 = 0; m3 < 4; m3++) begin
                c = mk(0, 1, 2, m2, m3, 0, 0, 0, 0, 0);
                write_cfg(1'b0, c);
                for (int p = 0; p < 8; p++) begin
                    drive({1'b0, 3'(p)}, 4'b0);
                    chk_comb("R3", c);
                end
            end
        end
    endtask

    task automatic t_and_or();
        logic [23:0] c_and, c_or;
        c_and = mk(0, 2, 0, 0, 2, 0, 0, 1, 2, 3);
        c_or  = mk(0, 0, 2, 3, 0, 0, 0, 1, 2, 3);
        write_cfg(1'b0, c_and);
        write_cfg(1'b1, c_or);
        for (int v = 0; v < 4; v++) begin
            set_ctx(1'b0);
            drive({1'b0, 1'(v >> 1), 1'b0, 1'(v)}, 4'b0);
            chk("R4", {4'b0, cell_f}, {4'b0, 1'(v == 3)});
            chk_comb("R4", c_and);
            set_ctx(1'b1);
            #1;
            chk("R4", {4'b0, cell_f}, {4'b0, 1'(v != 0)});
            chk_comb("R4", c_or);
        end
        set_ctx(1'b0);
    endtask

    task automatic t_route();
        logic [23:0] c;
        for (int code = 0; code < 4; code++) begin
            c = mk(4, 4, 4, 0, 0, 0, code, code, code, code);
            write_cfg(1'b0, c);
            for (int p = 0; p < 32; p++) begin
                drive(4'(p), {3'b0, 1'(p >> 4)});
                chk_comb("R7", c);
            end
            for (int d = 0; d < 4; d++) begin
                drive(4'(1 << d), 4'b0);
                if (code != 0) chk("R7 own side", {3'b0, dir_out[d], 1'b0}, 5'b0);
            end
        end
    endtask

    task automatic t_registered();
        write_cfg(1'b0, mk(0, 2, 0, 0, 2, 1, 0, 0, 0, 0));
        drive(4'b0101, 4'b0);
        @(posedge clk); #1;
        chk("R5", {4'b0, cell_f}, 5'b00001);
        drive(4'b0001, 4'b0);
        chk("R5 hold", {dir_out, cell_f}, 5'b11111);
        @(posedge clk); #1;
        chk("R5", {dir_out, cell_f}, 5'b00000);
    endtask

    task automatic t_clear();
        write_cfg(1'b0, mk(0, 0, 0, 3, 3, 1, 0, 0, 0, 0));
        drive(4'b0000, 4'b0);
        @(posedge clk); #1;
        chk("R6 prep", {4'b0, cell_f}, 5'b00001);
        @(negedge clk); clr = 1'b1;
        @(posedge clk); #1;
        chk("R6", {4'b0, cell_f}, 5'b00000);
        @(negedge clk); clr = 1'b0;
        @(posedge clk); #1;
        chk("R6 release", {4'b0, cell_f}, 5'b00001);
    endtask

    task automatic t_ctx_timing();
        write_cfg(1'b0, mk(0, 2, 0, 0, 2, 0, 0, 0, 0, 0));
        write_cfg(1'b1, mk(0, 0, 2, 3, 0, 0, 0, 0, 0, 0));
        set_ctx(1'b0);
        drive(4'b0001, 4'b0);
        chk("R8 base", {4'b0, cell_f}, 5'b00000);
        @(negedge clk); ctx_sel = 1'b1; #1;
        chk("R8 before edge", {4'b0, cell_f}, 5'b00000);
        @(posedge clk); #1;
        chk("R8 after edge", {4'b0, cell_f}, 5'b00001);
        // registered path
        write_cfg(1'b0, mk(0, 2, 0, 0, 2, 1, 0, 0, 0, 0));
        write_cfg(1'b1, mk(0, 0, 2, 3, 0, 1, 0, 0, 0, 0));
        set_ctx(1'b0);
        @(posedge clk); #1;
        chk("R8 reg base", {4'b0, cell_f}, 5'b00000);
        @(negedge clk); ctx_sel = 1'b1;
        @(posedge clk); #1;
        chk("R8 reg old ctx", {4'b0, cell_f}, 5'b00000);
        @(posedge clk); #1;
        chk("R8 reg new ctx", {4'b0, cell_f}, 5'b00001);
        set_ctx(1'b0);
    endtask

    task automatic t_inactive_write();
        logic [23:0] c_act, c_new;
        c_act = mk(0, 2, 0, 0, 2, 0, 0, 1, 2, 3);
        c_new = mk(1, 1, 1, 1, 1, 0, 3, 3, 3, 3);
        write_cfg(1'b0, c_act);
        set_ctx(1'b0);
        drive(4'b0101, 4'b0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 1'b1; cfg_data = c_new;
        #1; chk_comb("R9 during", c_act);
        @(posedge clk); #1;
        chk_comb("R9 after", c_act);
        @(negedge clk); cfg_we = 1'b0;
        #1; chk_comb("R9 settled", c_act);
        set_ctx(1'b1);
        #1; chk_comb("R9 landed", c_new);
        set_ctx(1'b0);
    endtask

    task automatic t_alternate();
        logic [23:0] cw [2];
        logic [3:0] nb;
        cw[0] = mk(0, 2, 0, 0, 2, 0, 0, 1, 2, 3);
        cw[1] = mk(0, 0, 2, 3, 0, 0, 0, 1, 2, 3);
        write_cfg(1'b0, cw[0]);
        write_cfg(1'b1, cw[1]);
        for (int i = 0; i < 16; i++) begin
            nb = 4'((i * 5) & 4'b0101) | 4'((i >> 2) & 4'b1010);
            @(negedge clk);
            ctx_sel = 1'(i & 1);
            nb_in = nb;
            @(posedge clk); #1;
            chk_comb("R10", cw[i & 1]);
        end
        set_ctx(1'b0);
    endtask

    task automatic t_spare();
        logic [23:0] c, cs;
        c  = mk(0, 2, 0, 0, 2, 0, 0, 1, 2, 3);
        cs = c | 24'hC00000;
        write_cfg(1'b0, cs);
        for (int v = 0; v < 16; v++) begin
            drive(4'(v), 4'b0);
            chk_comb("R11", c);
        end
    endtask

    initial begin
        t_reset();
        t_operand();
        t_ymodes();
        t_and_or();
        t_route();
        t_registered();
        t_clear();
        t_ctx_timing();
        t_inactive_write();
        t_alternate();
        t_spare();
        run_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!run_done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule